// File: doc/BRIEF.md
# BCD Calendar Counter with Century

This core keeps wall-clock time and calendar date in packed BCD: seconds, minutes, hours (24-hour), day of week, day of month, month and a two-digit year. A 2-bit binary century field sits above the year. An oscillator-derived tick drives a sub-second divider. Each time the divider completes, the time advances by one second and carries ripple up through the calendar. Month lengths and leap years are handled in hardware. The century field decides whether year 00 is a leap year.

A parallel load port writes the seven time registers and a control byte that holds the output level bit. Any write to a time register also restarts the sub-second divider. A stop bit freezes time. A freeze input holds the copy that is read, while an internal shadow copy keeps counting, so no second is lost during a multi-byte read. One active-low pin serves two purposes. With the oscillator-fail interrupt enabled it flags a stopped oscillator. With the interrupt disabled it follows a software output bit.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the time reads 00:00:00, day of week 1, date 01, month 01, year 00, century 0. The stop bit and the interrupt enable are 0, the output bit is 1, and read address 7 returns 0x80.
- R2: Seconds advance by one after every TICKS_PER_SEC accepted ticks. BCD carries ripple seconds 59→00 into minutes, minutes 59→00 into hours, and hours 23→00 into the day.
- R3: At midnight the day of week goes from 7 to 1 and otherwise increments by one, independent of the date.
- R4: The date rolls to 01 and the month advances after day 30 in months 04, 06, 09 and 11, and after day 31 in the other months except February.
- R5: February has 29 days when the BCD year (other than 00) is divisible by four, and 28 days otherwise.
- R6: Year 00 is a leap year only with century 0. Month 12 rolls to 01 and year 99 rolls to 00, and at that point the century increments modulo 4.
- R7: While the stop bit (address 0, bit 7) is 1, or osc_running_i is 0, ticks are ignored and the time holds. Clearing the stop bit resumes counting.
- R8: A write to any address 0 to 6 loads that field and clears the sub-second divider. The field layout is:
  - address 0: {stop, seconds}
  - address 1: {interrupt enable, minutes}
  - address 2: hours in bits 5:0
  - address 3: day of week in bits 2:0
  - address 4: date in bits 5:0
  - address 5: {century in bits 7:6, month in bits 4:0}
  - address 6: year

  A write to address 7 sets only the output bit (bit 7) and leaves the divider running.
- R9: While freeze_i is 1 the readable time registers hold their value. Ticks still advance the shadow time, and that time appears one cycle after freeze_i falls.
- R10: With the interrupt enable at 1, irq_out_no is 0 when the stop bit is 1 or osc_running_i is 0, and 1 otherwise. With the enable at 0, irq_out_no equals the output bit.
- R11: stopped_o equals the stop bit, and osc_fail_o is 1 when the stop bit is 1 or osc_running_i is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Oscillator-derived sub-second tick, one cycle wide |
| osc_running_i | input | 1 | Oscillator activity flag |
| freeze_i | input | 1 | Hold the readable copy of the time registers |
| wr_en_i | input | 1 | Load strobe |
| wr_addr_i | input | 3 | Load address |
| wr_data_i | input | 8 | Load data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 8 | Read data, combinational from the readable copy |
| stopped_o | output | 1 | Stop bit status |
| osc_fail_o | output | 1 | Oscillator stopped, by the stop bit or by the flag |
| irq_out_no | output | 1 | Active-low interrupt or output-level pin |

## Verification
Sixteen start times are each advanced by exactly one second.

- Some cases exercise the plain BCD carry within the seconds digit and the ripple through minutes and hours.
- Midnight cases separate the day-of-week wrap from date rollover.
- February cases in years 24, 12, 10, 25 and 00 under different centuries tell the ordinary divisible-by-four rule apart from the century-dependent year-00 rule.
- A 99-to-00 rollover at century 3 shows the century wrap.

Directed sequences place writes partway through a second to tell a divider restart (addresses 0 to 6) apart from a plain control write (address 7). They also show that stop and a missing oscillator hold time, that freeze hides ticks without losing them, and they walk the pin through all enable, stop and output combinations.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;
  localparam logic [ADDR_W-1:0] LAST_TIME_ADDR = 3'd6;

  typedef struct packed {
    logic [1:0] cent;
    logic [7:0] year;
    logic [4:0] month;
    logic [5:0] date;
    logic [2:0] wday;
    logic [5:0] hour;
    logic [6:0] minute;
    logic [6:0] second;
  } cal_t;

  localparam cal_t CAL_RST = '{cent: 2'd0, year: 8'h00, month: 5'h01, date: 6'h01,
                               wday: 3'd1, hour: 6'h00, minute: 7'h00, second: 7'h00};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic is_leap(input logic [7:0] yr, input logic [1:0] cent);
    logic [6:0] bin;
    bin = 7'(yr[7:4]) * 7'd10 + 7'(yr[3:0]);
    if (yr == 8'h00) return cent == 2'd0;
    return bin[1:0] == 2'b00;
  endfunction

  function automatic logic [5:0] month_len(input logic [4:0] mon, input logic leap);
    case (mon)
      5'h02:                      return leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_subsec_div.sv
module rtc_subsec_div #(
  parameter int TICKS_PER_SEC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic run_i,
  input  logic clear_i,
  output logic sec_pulse_o
);
  localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] cnt_q;
  logic          step;

  assign step        = tick_i && run_i && !clear_i;
  assign sec_pulse_o = step && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (clear_i)     cnt_q <= '0;
    else if (sec_pulse_o) cnt_q <= '0;
    else if (step)        cnt_q <= cnt_q + 1'b1;
  end

  assert_div_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> cnt_q == '0);
  assert_div_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clear_i) |=> $stable(cnt_q));
endmodule

// File: rtl/rtc_time_regs.sv
module rtc_time_regs
  import rtc_cal_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sec_pulse_i,
  input  logic              ld_en_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic [DATA_W-1:0] ld_data_i,
  output logic              st_o,
  output logic              ofie_o,
  output cal_t              time_next_o
);
  cal_t cur_q, nxt;
  logic st_q, ofie_q;
  logic s_wrap, m_wrap, h_wrap, d_wrap, mo_wrap, y_wrap;
  logic c_min, c_hour, c_day, c_mon, c_year, c_cent;

  assign s_wrap  = cur_q.second == 7'h59;
  assign m_wrap  = cur_q.minute == 7'h59;
  assign h_wrap  = cur_q.hour   == 6'h23;
  assign d_wrap  = cur_q.date   == month_len(cur_q.month, is_leap(cur_q.year, cur_q.cent));
  assign mo_wrap = cur_q.month  == 5'h12;
  assign y_wrap  = cur_q.year   == 8'h99;

  assign c_min  = sec_pulse_i && s_wrap;
  assign c_hour = c_min  && m_wrap;
  assign c_day  = c_hour && h_wrap;
  assign c_mon  = c_day  && d_wrap;
  assign c_year = c_mon  && mo_wrap;
  assign c_cent = c_year && y_wrap;

  always_comb begin
    nxt = cur_q;
    if (sec_pulse_i) nxt.second = s_wrap ? 7'h00 : 7'(bcd_inc({1'b0, cur_q.second}));
    if (c_min)  nxt.minute = m_wrap ? 7'h00 : 7'(bcd_inc({1'b0, cur_q.minute}));
    if (c_hour) nxt.hour   = h_wrap ? 6'h00 : 6'(bcd_inc({2'b0, cur_q.hour}));
    if (c_day) begin
      nxt.wday = (cur_q.wday == 3'd7) ? 3'd1 : cur_q.wday + 3'd1;
      nxt.date = d_wrap ? 6'h01 : 6'(bcd_inc({2'b0, cur_q.date}));
    end
    if (c_mon)  nxt.month = mo_wrap ? 5'h01 : 5'(bcd_inc({3'b0, cur_q.month}));
    if (c_year) nxt.year  = y_wrap ? 8'h00 : bcd_inc(cur_q.year);
    if (c_cent) nxt.cent  = cur_q.cent + 2'd1;
    if (ld_en_i) begin
      case (ld_addr_i)
        3'd0:    nxt.second = ld_data_i[6:0];
        3'd1:    nxt.minute = ld_data_i[6:0];
        3'd2:    nxt.hour   = ld_data_i[5:0];
        3'd3:    nxt.wday   = ld_data_i[2:0];
        3'd4:    nxt.date   = ld_data_i[5:0];
        3'd5:    begin nxt.cent = ld_data_i[7:6]; nxt.month = ld_data_i[4:0]; end
        default: nxt.year   = ld_data_i;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= CAL_RST;
      st_q   <= 1'b0;
      ofie_q <= 1'b0;
    end else begin
      cur_q <= nxt;
      if (ld_en_i && ld_addr_i == 3'd0) st_q   <= ld_data_i[7];
      if (ld_en_i && ld_addr_i == 3'd1) ofie_q <= ld_data_i[7];
    end
  end

  assign st_o        = st_q;
  assign ofie_o      = ofie_q;
  assign time_next_o = nxt;

  assert_sec_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_pulse_i && !ld_en_i && cur_q.second == 7'h59) |=> cur_q.second == 7'h00);
  assert_wday_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_day && !ld_en_i && cur_q.wday == 3'd7) |=> cur_q.wday == 3'd1);
  assert_century_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_cent && !ld_en_i) |=> cur_q.cent == $past(cur_q.cent) + 2'd1);
  assert_stop_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q && !ld_en_i) |=> $stable(cur_q));
endmodule

// File: rtl/rtc_irq_pin.sv
module rtc_irq_pin (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ofie_i,
  input  logic st_i,
  input  logic osc_running_i,
  input  logic out_bit_i,
  output logic osc_fail_o,
  output logic pin_no
);
  assign osc_fail_o = st_i || !osc_running_i;
  assign pin_no     = ofie_i ? !osc_fail_o : out_bit_i;

  assert_irq_active_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ofie_i && !osc_running_i) |-> !pin_no);
  assert_out_follow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ofie_i) |-> pin_no == out_bit_i);
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_cal_pkg::*;
#(
  parameter int TICKS_PER_SEC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              osc_running_i,
  input  logic              freeze_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              stopped_o,
  output logic              osc_fail_o,
  output logic              irq_out_no
);
  logic ld_time, sec_pulse, st, ofie, out_q;
  cal_t time_nxt, vis_q;

  assign ld_time = wr_en_i && (wr_addr_i <= LAST_TIME_ADDR);

  rtc_subsec_div #(.TICKS_PER_SEC(TICKS_PER_SEC)) i_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .run_i(!st && osc_running_i), .clear_i(ld_time), .sec_pulse_o(sec_pulse)
  );

  rtc_time_regs i_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .sec_pulse_i(sec_pulse),
    .ld_en_i(ld_time), .ld_addr_i(wr_addr_i), .ld_data_i(wr_data_i),
    .st_o(st), .ofie_o(ofie), .time_next_o(time_nxt)
  );

  rtc_irq_pin i_pin (
    .clk_i(clk_i), .rst_ni(rst_ni), .ofie_i(ofie), .st_i(st),
    .osc_running_i(osc_running_i), .out_bit_i(out_q),
    .osc_fail_o(osc_fail_o), .pin_no(irq_out_no)
  );

  // readable copy tracks next state so it never lags the shadow when unfrozen
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vis_q <= CAL_RST;
      out_q <= 1'b1;
    end else begin
      if (!freeze_i) vis_q <= time_nxt;
      if (wr_en_i && wr_addr_i == 3'd7) out_q <= wr_data_i[7];
    end
  end

  always_comb begin
    case (rd_addr_i)
      3'd0:    rd_data_o = {st, vis_q.second};
      3'd1:    rd_data_o = {ofie, vis_q.minute};
      3'd2:    rd_data_o = {2'b00, vis_q.hour};
      3'd3:    rd_data_o = {5'b0, vis_q.wday};
      3'd4:    rd_data_o = {2'b00, vis_q.date};
      3'd5:    rd_data_o = {vis_q.cent, 1'b0, vis_q.month};
      3'd6:    rd_data_o = vis_q.year;
      default: rd_data_o = {out_q, 7'b0};
    endcase
  end

  assign stopped_o = st;

  assert_freeze_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_i |=> vis_q == $past(vis_q));
  assert_stop_status_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 3'd0) |=> stopped_o == $past(wr_data_i[7]));
endmodule

// File: tb/test_rtc_calendar_core.sv
`timescale 1ns/1ps
module test_rtc_calendar_core;
  localparam int TPS = 4;
  localparam int NV  = 16;
  // {start sec,min,hour,wday,date,cent|month,year ; expected after one second}
  localparam logic [111:0] VEC [NV] = '{
    {56'h00_00_00_01_01_01_00, 56'h01_00_00_01_01_01_00},
    {56'h09_00_00_01_01_01_00, 56'h10_00_00_01_01_01_00},
    {56'h59_59_12_03_15_06_24, 56'h00_00_13_03_15_06_24},
    {56'h59_59_23_07_10_03_25, 56'h00_00_00_01_11_03_25},
    {56'h59_59_23_02_30_04_25, 56'h00_00_00_03_01_05_25},
    {56'h59_59_23_02_30_05_25, 56'h00_00_00_03_31_05_25},
    {56'h59_59_23_04_31_01_25, 56'h00_00_00_05_01_02_25},
    {56'h59_59_23_04_28_02_24, 56'h00_00_00_05_29_02_24},
    {56'h59_59_23_04_29_02_24, 56'h00_00_00_05_01_03_24},
    {56'h59_59_23_04_28_02_25, 56'h00_00_00_05_01_03_25},
    {56'h59_59_23_04_28_02_12, 56'h00_00_00_05_29_02_12},
    {56'h59_59_23_04_28_02_10, 56'h00_00_00_05_01_03_10},
    {56'h59_59_23_04_28_02_00, 56'h00_00_00_05_29_02_00},
    {56'h59_59_23_04_28_42_00, 56'h00_00_00_05_01_43_00},
    {56'h59_59_23_06_31_12_99, 56'h00_00_00_07_01_41_00},
    {56'h59_59_23_06_31_D2_99, 56'h00_00_00_07_01_01_00}
  };

  function automatic string req_of(input int i);
    case (i)
      0, 1, 2:        return "R2";
      3:              return "R3";
      4, 5, 6:        return "R4";
      7, 8, 9, 10, 11: return "R5";
      default:        return "R6";
    endcase
  endfunction

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, osc = 1'b1, frz = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic stopped, osc_fail, pin_n;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  rtc_calendar_core #(.TICKS_PER_SEC(TPS)) i_rtc_calendar_core (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .osc_running_i(osc),
    .freeze_i(frz), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .stopped_o(stopped),
    .osc_fail_o(osc_fail), .irq_out_no(pin_n)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      tick = 1'b1; @(posedge clk); @(negedge clk);
    end
    tick = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
    rd_addr = a; #1;
    chk(req, $sformatf("addr%0d", a), rd_data, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd_chk("R1", 3'd0, 8'h00); rd_chk("R1", 3'd1, 8'h00); rd_chk("R1", 3'd2, 8'h00);
    rd_chk("R1", 3'd3, 8'h01); rd_chk("R1", 3'd4, 8'h01); rd_chk("R1", 3'd5, 8'h01);
    rd_chk("R1", 3'd6, 8'h00); rd_chk("R1", 3'd7, 8'h80);
    chk("R1", "pin", {7'b0, pin_n}, 8'h01);
    chk("R11", "stopped", {7'b0, stopped}, 8'h00);
    chk("R11", "osc_fail", {7'b0, osc_fail}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [55:0] s, e;
      s = VEC[i][111:56]; e = VEC[i][55:0];
      for (int k = 0; k < 7; k++) wr(3'(k), s[55-8*k -: 8]);
      ticks(TPS);
      for (int k = 0; k < 7; k++) begin
        rd_addr = 3'(k); #1;
        chk(req_of(i), $sformatf("vec%0d addr%0d", i, k), rd_data, e[55-8*k -: 8]);
      end
    end

    // R7 stop bit and missing oscillator
    wr(3'd0, 8'h85);
    ticks(2 * TPS);
    rd_chk("R7", 3'd0, 8'h85);
    chk("R11", "stopped", {7'b0, stopped}, 8'h01);
    chk("R11", "osc_fail", {7'b0, osc_fail}, 8'h01);
    wr(3'd0, 8'h05);
    ticks(TPS);
    rd_chk("R7", 3'd0, 8'h06);
    osc = 1'b0;
    ticks(2 * TPS);
    rd_chk("R7", 3'd0, 8'h06);
    chk("R11", "osc_fail", {7'b0, osc_fail}, 8'h01);
    osc = 1'b1;

    // R8 divider restart on time writes, not on address 7
    wr(3'd0, 8'h10);
    ticks(2);
    wr(3'd1, 8'h00);
    ticks(TPS - 2);
    rd_chk("R8", 3'd0, 8'h10);
    ticks(2);
    rd_chk("R8", 3'd0, 8'h11);
    ticks(2);
    wr(3'd7, 8'h00);
    ticks(TPS - 2);
    rd_chk("R8", 3'd0, 8'h12);
    rd_chk("R8", 3'd7, 8'h00);
    chk("R10", "pin out=0", {7'b0, pin_n}, 8'h00);

    // R9 freeze hides ticks without losing them
    frz = 1'b1;
    ticks(TPS);
    rd_chk("R9", 3'd0, 8'h12);
    frz = 1'b0;
    @(posedge clk); @(negedge clk);
    rd_chk("R9", 3'd0, 8'h13);

    // R10 pin modes
    wr(3'd1, 8'h80);
    chk("R10", "pin ofie run", {7'b0, pin_n}, 8'h01);
    osc = 1'b0; #1;
    chk("R10", "pin ofie nosc", {7'b0, pin_n}, 8'h00);
    osc = 1'b1; #1;
    chk("R10", "pin ofie osc back", {7'b0, pin_n}, 8'h01);
    wr(3'd0, 8'h80);
    chk("R10", "pin ofie st", {7'b0, pin_n}, 8'h00);
    wr(3'd0, 8'h00);
    chk("R10", "pin ofie st clr", {7'b0, pin_n}, 8'h01);
    wr(3'd1, 8'h00);
    chk("R10", "pin out=0", {7'b0, pin_n}, 8'h00);
    wr(3'd7, 8'h80);
    chk("R10", "pin out=1", {7'b0, pin_n}, 8'h01);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule